// File: doc/BRIEF.md
# PHY register access bridge

This block sits between a host control register and a small register file inside a PHY. Software reaches the PHY registers indirectly: it writes one 32-bit control word that carries a PHY address, a write-data byte and two strobe bits. The bridge turns the 0-to-1 edge of a strobe into exactly one request on a PHY-side request/acknowledge port. It reports completion through an acknowledge flag in the same word, and on reads it returns the PHY byte in a dedicated field.

The handshake is driven by software and works on levels. Software first writes the address and data with both strobes low. It then rewrites the word with one strobe set and polls the acknowledge flag. Finally it clears the strobe to close the access. A behavioural PHY register file with a configurable response latency is part of the block. It holds per-speed-mode input-delay entries at addresses 0x00 to 0x08 and clock/strobe DLL delay entries at 0x0B to 0x0D. Its contents are also driven out on a flat tap bus.

Top module: `phy_regbridge`

## Requirements
- R1: After reset the control word reads 0x0000_0000 and every byte of the tap bus is zero.
- R2: The control word holds the PHY address in bits 7:0 and the write data in bits 15:8, both readable as written. The read-data byte is in bits 23:16 and cannot be written by the host. Bits 31:27 always read as zero.
- R3: A write access happens when the write strobe (bit 24) rises. It stores the write-data byte at the PHY address, and the acknowledge flag (bit 26) sets within ACK_BOUND clock cycles of the strobe write.
- R4: A read access happens when the read strobe (bit 25) rises. It returns the addressed PHY byte in bits 23:16, valid no later than the acknowledge flag.
- R5: A request is issued only on a 0-to-1 strobe transition. Rewriting the word with the strobe still high starts no further access, and the PHY request drops after its acknowledge.
- R6: The acknowledge flag stays set while the strobe stays high. It reads zero in the cycle after the host write that clears both strobes, and it is zero whenever both strobes are low.
- R7: If the write and read strobes rise in the same host write, no PHY access takes place and the acknowledge flag stays clear.
- R8: The read-data field keeps its value until the next completed read access. Write accesses do not change it.
- R9: The address and write-data fields may be rewritten at any time. A request already in flight uses the address, data and direction captured at its strobe edge.
- R10: Addresses other than 0x00 to 0x08 and 0x0B to 0x0D are still acknowledged. Writes to them change nothing, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_we | input | 1 | Host write enable for the control word |
| host_wdata | input | 32 | Control word written by the host |
| host_rdata | output | 32 | Control word read back by the host |
| dly_taps | output | 112 | PHY register file contents, byte i at bits 8*i+7:8*i |

## Verification
The main function is tried with three-step writes and reads to the low and high ends of both implemented address ranges and to unimplemented addresses. These patterns tell correct address decoding apart from aliasing or dropped writes. A strobe held high while the data field changes separates edge-triggered launch from level-triggered launch. A simultaneous rise of both strobes separates an arbitration bug from correct rejection. A field rewrite during an in-flight request shows whether the request operands were snapshotted. A write that follows a read shows whether the read-data byte is held or overwritten.

// File: rtl/phyb_pkg.sv
package phyb_pkg;
    localparam int WORD_W    = 32;
    localparam int FIELD_W   = 8;
    localparam int ADDR_LSB  = 0;
    localparam int WDAT_LSB  = 8;
    localparam int RDAT_LSB  = 16;
    localparam int WSTB_BIT  = 24;
    localparam int RSTB_BIT  = 25;
    localparam int ACK_BIT   = 26;
    localparam int NUM_SLOTS = 14;
    localparam int SLOT_IW   = $clog2(NUM_SLOTS);

    typedef enum logic {REQ_IDLE, REQ_BUSY} req_state_e;

    // Implemented entries: input delays 0x00..0x08, DLL delays 0x0B..0x0D
    function automatic logic slot_impl(input logic [FIELD_W-1:0] a);
        return (a <= 8'd8) || ((a >= 8'd11) && (a <= 8'd13));
    endfunction
endpackage

// File: rtl/phyb_ctrl.sv
module phyb_ctrl
    import phyb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [WORD_W-1:0]  host_wdata,
    output logic [FIELD_W-1:0] addr_q,
    output logic [FIELD_W-1:0] wdata_q,
    output logic               wr_stb_q,
    output logic               rd_stb_q,
    output logic               stb_any_d,
    output logic               launch_wr,
    output logic               launch_rd
);
    typedef struct packed {
        logic [FIELD_W-1:0] addr;
        logic [FIELD_W-1:0] wdata;
        logic               wr_stb;
        logic               rd_stb;
    } ctrl_s;

    ctrl_s cur_q, nxt_d;
    logic  rise_wr, rise_rd;
    logic  unused_bits;

    assign unused_bits = ^{host_wdata[WORD_W-1:ACK_BIT], host_wdata[RDAT_LSB +: FIELD_W]};

    always_comb begin
        nxt_d   = cur_q;
        rise_wr = 1'b0;
        rise_rd = 1'b0;
        if (host_we) begin
            nxt_d.addr   = host_wdata[ADDR_LSB +: FIELD_W];
            nxt_d.wdata  = host_wdata[WDAT_LSB +: FIELD_W];
            nxt_d.wr_stb = host_wdata[WSTB_BIT];
            nxt_d.rd_stb = host_wdata[RSTB_BIT];
            rise_wr      = host_wdata[WSTB_BIT] & ~cur_q.wr_stb;
            rise_rd      = host_wdata[RSTB_BIT] & ~cur_q.rd_stb;
        end
        launch_wr = rise_wr & ~rise_rd;
        launch_rd = rise_rd & ~rise_wr;
        stb_any_d = nxt_d.wr_stb | nxt_d.rd_stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign addr_q   = cur_q.addr;
    assign wdata_q  = cur_q.wdata;
    assign wr_stb_q = cur_q.wr_stb;
    assign rd_stb_q = cur_q.rd_stb;
endmodule

// File: rtl/phyb_req.sv
module phyb_req
    import phyb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch_wr,
    input  logic               launch_rd,
    input  logic [FIELD_W-1:0] snap_addr,
    input  logic [FIELD_W-1:0] snap_wdata,
    input  logic               stb_any_d,
    input  logic               phy_ack,
    input  logic [FIELD_W-1:0] phy_rdata,
    output logic               phy_req,
    output logic [FIELD_W-1:0] req_addr,
    output logic [FIELD_W-1:0] req_wdata,
    output logic               req_rd,
    output logic               ack_flag,
    output logic [FIELD_W-1:0] rd_data
);
    typedef struct packed {
        req_state_e         state;
        logic [FIELD_W-1:0] addr;
        logic [FIELD_W-1:0] wdata;
        logic               rd;
        logic               ack;
        logic [FIELD_W-1:0] rdata;
    } req_s;

    req_s cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.state)
            REQ_IDLE: begin
                if (launch_wr || launch_rd) begin
                    nxt_d.state = REQ_BUSY;
                    nxt_d.addr  = snap_addr;
                    nxt_d.wdata = snap_wdata;
                    nxt_d.rd    = launch_rd;
                    nxt_d.ack   = 1'b0;
                end
            end
            REQ_BUSY: begin
                if (phy_ack) begin
                    nxt_d.state = REQ_IDLE;
                    if (cur_q.rd) nxt_d.rdata = phy_rdata;
                    nxt_d.ack = 1'b1;
                end
            end
            default: nxt_d.state = REQ_IDLE;
        endcase
        if (!stb_any_d) nxt_d.ack = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign phy_req   = (cur_q.state == REQ_BUSY);
    assign req_addr  = cur_q.addr;
    assign req_wdata = cur_q.wdata;
    assign req_rd    = cur_q.rd;
    assign ack_flag  = cur_q.ack;
    assign rd_data   = cur_q.rdata;
endmodule

// File: rtl/phyb_phy_model.sv
module phyb_phy_model
    import phyb_pkg::*;
#(
    parameter int ACK_DELAY = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic [FIELD_W-1:0]           addr,
    input  logic [FIELD_W-1:0]           wdata,
    input  logic                         rd,
    output logic                         ack,
    output logic [FIELD_W-1:0]           rdata,
    output logic [NUM_SLOTS*FIELD_W-1:0] taps
);
    localparam int CW = $clog2(ACK_DELAY + 1);

    typedef struct packed {
        logic [CW-1:0]                         cnt;
        logic                                  ack;
        logic [FIELD_W-1:0]                    rdata;
        logic [NUM_SLOTS-1:0][FIELD_W-1:0]     slots;
    } phy_s;

    phy_s cur_q, nxt_d;
    logic [SLOT_IW-1:0] idx;

    assign idx = addr[SLOT_IW-1:0];

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.ack = 1'b0;
        if (req && !cur_q.ack) begin
            if (cur_q.cnt == CW'(ACK_DELAY - 1)) begin
                nxt_d.cnt = '0;
                nxt_d.ack = 1'b1;
                if (rd) begin
                    nxt_d.rdata = slot_impl(addr) ? cur_q.slots[idx] : '0;
                end else if (slot_impl(addr)) begin
                    nxt_d.slots[idx] = wdata;
                end
            end else begin
                nxt_d.cnt = cur_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ack   = cur_q.ack;
    assign rdata = cur_q.rdata;

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_tap
        if (slot_impl(FIELD_W'(g))) begin : g_live
            assign taps[g*FIELD_W +: FIELD_W] = cur_q.slots[g];
        end else begin : g_hole
            assign taps[g*FIELD_W +: FIELD_W] = '0;
        end
    end
endmodule

// File: rtl/phy_regbridge.sv
module phy_regbridge
    import phyb_pkg::*;
#(
    parameter int ACK_DELAY = 3,
    parameter int ACK_BOUND = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_we,
    input  logic [31:0]                  host_wdata,
    output logic [31:0]                  host_rdata,
    output logic [NUM_SLOTS*8-1:0]       dly_taps
);
    logic [FIELD_W-1:0] addr_q, wdata_q, req_addr, req_wdata, rd_data, phy_rdata;
    logic               wr_stb_q, rd_stb_q, stb_any_d, launch_wr, launch_rd;
    logic               phy_req, phy_ack, req_rd, ack_flag;

    phyb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_we),
        .host_wdata(host_wdata),
        .addr_q    (addr_q),
        .wdata_q   (wdata_q),
        .wr_stb_q  (wr_stb_q),
        .rd_stb_q  (rd_stb_q),
        .stb_any_d (stb_any_d),
        .launch_wr (launch_wr),
        .launch_rd (launch_rd)
    );

    phyb_req u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_wr (launch_wr),
        .launch_rd (launch_rd),
        .snap_addr (host_wdata[ADDR_LSB +: FIELD_W]),
        .snap_wdata(host_wdata[WDAT_LSB +: FIELD_W]),
        .stb_any_d (stb_any_d),
        .phy_ack   (phy_ack),
        .phy_rdata (phy_rdata),
        .phy_req   (phy_req),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_rd    (req_rd),
        .ack_flag  (ack_flag),
        .rd_data   (rd_data)
    );

    phyb_phy_model #(.ACK_DELAY(ACK_DELAY)) u_phy (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (phy_req),
        .addr (req_addr),
        .wdata(req_wdata),
        .rd   (req_rd),
        .ack  (phy_ack),
        .rdata(phy_rdata),
        .taps (dly_taps)
    );

    assign host_rdata = {5'd0, ack_flag, rd_stb_q, wr_stb_q, rd_data, wdata_q, addr_q};
endmodule

// File: rtl/phy_regbridge_chk.sv
module phy_regbridge_chk #(
    parameter int ACK_BOUND = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] word,
    input logic        phy_req,
    input logic        phy_ack,
    input logic        req_rd,
    input logic [7:0]  req_addr,
    input logic [7:0]  req_wdata,
    input logic [7:0]  rdata_fld
);
    logic [15:0] wait_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                wait_cnt <= '0;
        else if (phy_req && !phy_ack) wait_cnt <= wait_cnt + 16'd1;
        else                       wait_cnt <= '0;
    end

    // R3
    ack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt < 16'(ACK_BOUND));

    // R5
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> phy_req);

    // R5
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_ack |=> !phy_req);

    // R6
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!word[24] && !word[25]) |-> !word[26]);

    // R7
    no_dual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phy_req) |-> !(word[24] && word[25] && !$past(word[24]) && !$past(word[25])));

    // R9
    stable_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> ($stable(req_addr) && $stable(req_wdata) && $stable(req_rd)));

    // R8
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(phy_ack && req_rd) |=> $stable(rdata_fld));

    // R2
    top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word[31:27] == 5'd0);
endmodule

bind phy_regbridge phy_regbridge_chk #(.ACK_BOUND(ACK_BOUND)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .word     (host_rdata),
    .phy_req  (phy_req),
    .phy_ack  (phy_ack),
    .req_rd   (req_rd),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rdata_fld(rd_data)
);

// File: tb/phy_regbridge_tb.sv
`timescale 1ns/1ps
module phy_regbridge_tb;
    localparam int SLOTS = 14;
    localparam int BOUND = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              host_we = 1'b0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic [SLOTS*8-1:0] dly_taps;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_slot [SLOTS];

    always #2.5 clk = ~clk;

    phy_regbridge #(.ACK_DELAY(3), .ACK_BOUND(BOUND)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .dly_taps(dly_taps)
    );

    function automatic logic [31:0] mk(input logic [7:0] a, input logic [7:0] d,
                                       input logic wr, input logic rd);
        return {5'd0, 1'b0, rd, wr, 8'h00, d, a};
    endfunction

    function automatic logic [SLOTS*8-1:0] exp_taps();
        logic [SLOTS*8-1:0] t;
        for (int i = 0; i < SLOTS; i++) t[i*8 +: 8] = exp_slot[i];
        return t;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic hwrite(input logic [31:0] w);
        host_we = 1'b1;
        host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_ack(output int n);
        n = 0;
        while (!host_rdata[26] && n < 2*BOUND) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic phy_write(input logic [7:0] a, input logic [7:0] d);
        int n;
        hwrite(mk(a, d, 1'b0, 1'b0));
        hwrite(mk(a, d, 1'b1, 1'b0));
        wait_ack(n);
        chk(host_rdata[26] && n < BOUND, "R3 write ack bit 26", n, BOUND);
        hwrite(mk(a, d, 1'b0, 1'b0));
        chk(!host_rdata[26], "R6 ack clear after strobe drop", host_rdata[26], 0);
        if (a <= 8'd8 || (a >= 8'd11 && a <= 8'd13)) exp_slot[a[3:0]] = d;
    endtask

    task automatic phy_read(input logic [7:0] a, output logic [7:0] v);
        int n;
        hwrite(mk(a, 8'h00, 1'b0, 1'b0));
        hwrite(mk(a, 8'h00, 1'b0, 1'b1));
        wait_ack(n);
        chk(host_rdata[26] && n < BOUND, "R4 read ack bit 26", n, BOUND);
        v = host_rdata[23:16];
        hwrite(mk(a, 8'h00, 1'b0, 1'b0));
        chk(!host_rdata[26], "R6 ack clear after read strobe drop", host_rdata[26], 0);
    endtask

    task automatic t_reset();
        chk(host_rdata == 32'h0, "R1 word after reset", host_rdata, 0);
        chk(dly_taps == '0, "R1 taps after reset", dly_taps, 0);
    endtask

    task automatic t_fields();
        hwrite({5'h1F, 3'b000, 8'hEE, 8'h3C, 8'hA5});
        chk(host_rdata == 32'h0000_3CA5, "R2 field readback", host_rdata, 32'h0000_3CA5);
        repeat (8) @(negedge clk);
        chk(dly_taps == exp_taps(), "R2 no access without strobe", dly_taps, exp_taps());
    endtask

    task automatic t_write();
        phy_write(8'h00, 8'h12);
        phy_write(8'h08, 8'h34);
        phy_write(8'h0D, 8'hC5);
        chk(dly_taps == exp_taps(), "R3 taps after writes", dly_taps, exp_taps());
    endtask

    task automatic t_read();
        logic [7:0] v;
        phy_read(8'h08, v);
        chk(v == 8'h34, "R4 read 0x08", v, 8'h34);
        phy_read(8'h0D, v);
        chk(v == 8'hC5, "R4 read 0x0D", v, 8'hC5);
    endtask

    task automatic t_hold();
        int n;
        hwrite(mk(8'h0B, 8'h21, 1'b0, 1'b0));
        hwrite(mk(8'h0B, 8'h21, 1'b1, 1'b0));
        wait_ack(n);
        exp_slot[11] = 8'h21;
        hwrite(mk(8'h0B, 8'h99, 1'b1, 1'b0));
        repeat (10) @(negedge clk);
        chk(host_rdata[26], "R6 ack held while strobe high", host_rdata[26], 1);
        chk(dly_taps == exp_taps(), "R5 held strobe no repeat", dly_taps, exp_taps());
        hwrite(mk(8'h0B, 8'h99, 1'b0, 1'b0));
        chk(!host_rdata[26], "R6 ack clear next cycle", host_rdata[26], 0);
    endtask

    task automatic t_both();
        logic [7:0] v;
        bit seen = 1'b0;
        hwrite(mk(8'h07, 8'h55, 1'b0, 1'b0));
        hwrite(mk(8'h07, 8'h55, 1'b1, 1'b1));
        for (int i = 0; i < 2*BOUND; i++) begin
            if (host_rdata[26]) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R7 no ack on dual strobe", seen, 0);
        hwrite(mk(8'h07, 8'h55, 1'b0, 1'b0));
        chk(dly_taps == exp_taps(), "R7 no write on dual strobe", dly_taps, exp_taps());
        phy_read(8'h07, v);
        chk(v == 8'h00, "R7 slot 0x07 untouched", v, 0);
    endtask

    task automatic t_inflight();
        int n;
        hwrite(mk(8'h03, 8'h11, 1'b0, 1'b0));
        hwrite(mk(8'h03, 8'h11, 1'b1, 1'b0));
        hwrite(mk(8'h05, 8'h99, 1'b1, 1'b0));
        chk(host_rdata[15:0] == 16'h9905, "R9 fields writable in flight", host_rdata[15:0], 16'h9905);
        wait_ack(n);
        chk(host_rdata[26], "R9 in-flight ack", host_rdata[26], 1);
        hwrite(mk(8'h05, 8'h99, 1'b0, 1'b0));
        exp_slot[3] = 8'h11;
        chk(dly_taps == exp_taps(), "R9 snapshot used", dly_taps, exp_taps());
    endtask

    task automatic t_rdata_hold();
        logic [7:0] v;
        phy_read(8'h00, v);
        chk(v == 8'h12, "R4 read 0x00", v, 8'h12);
        phy_write(8'h01, 8'h66);
        chk(host_rdata[23:16] == 8'h12, "R8 read field held", host_rdata[23:16], 8'h12);
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        phy_write(8'h0A, 8'h77);
        phy_write(8'hFF, 8'h42);
        chk(dly_taps == exp_taps(), "R10 holes ignore writes", dly_taps, exp_taps());
        phy_read(8'h0A, v);
        chk(v == 8'h00, "R10 read 0x0A", v, 0);
        phy_read(8'hFF, v);
        chk(v == 8'h00, "R10 read 0xFF", v, 0);
    endtask

    initial begin
        for (int i = 0; i < SLOTS; i++) exp_slot[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_write();
        t_read();
        t_hold();
        t_both();
        t_inflight();
        t_rdata_hold();
        t_unimpl();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule